// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block produces the system reset for a processor subsystem. Three causes can hold reset active. The first is power-up, marked by a power-on input. The second is a low supply, reported as a synchronous "supply above threshold" flag from an external comparator. The third is a watchdog that the host must service by driving the chip-select line from high to low. Reset is driven on two outputs of opposite polarity, so that both active-high and active-low consumers can be served.

All durations are measured in units. A unit is one pulse from an internal prescaler, which divides the external timebase tick by `PRESC_DIV`. Every duration is a parameter given as a count of units. On silicon the nominal values are about 200 ms for the supply qualification window and for the watchdog reset pulse. The three watchdog periods are about 1.4 s, 600 ms and 200 ms. Simulation uses short counts. The 2-bit period select chooses one of the three watchdog periods, and its fourth code switches the watchdog off.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1. After `por_n` rises with `supply_ok` high, reset stays asserted through `PUP_UNITS-1` units and is released on the clock edge of the `PUP_UNITS`-th unit.
- R2: When `supply_ok` is sampled low on a clock edge, `rst_out` is 1 after that edge. Release then needs a fresh qualification of `PUP_UNITS` units.
- R3: If `supply_ok` drops at any time during the qualification window, the unit count restarts from zero.
- R4: Watchdog period by `wd_sel`: code 2'b00 gives `WD_LONG_UNITS`, code 2'b01 gives `WD_MID_UNITS`, and code 2'b10 gives `WD_SHORT_UNITS`. Counting starts from the release of reset or from the last restart. Reset asserts on the edge of the unit that completes the period.
- R5: Code 2'b11 on `wd_sel` disables the watchdog, so it never expires.
- R6: Only a high-to-low change of `kick_cs` restarts the watchdog count. A rising edge does not restart it, and neither does a level held high or low.
- R7: A watchdog expiry holds reset for `RST_UNITS` units and then releases it.
- R8: The watchdog count is held at zero while reset is active, and it starts again from zero when reset releases.
- R9: Any change of `wd_sel` restarts the watchdog count.
- R10: `rst_out_n` is always the complement of `rst_out`.
- R11: One unit is produced every `PRESC_DIV` timebase ticks, counted from power-up. A partial group of ticks advances nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on indication, low while power is coming up |
| tick | input | 1 | Timebase pulse, one clock wide |
| supply_ok | input | 1 | Synchronous flag, high when the supply is above the trip level |
| kick_cs | input | 1 | Chip-select line; a falling edge services the watchdog |
| wd_sel | input | 2 | Watchdog period select (2'b11 = off) |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |

## Verification
A table drives each period code from a fresh power-up. Some runs leave the kick line untouched and others kick part-way through the period. The untouched runs separate the three period lengths from one another and from the disabled code. The kicked runs show whether the count truly restarts or only pauses. Directed cases cover the following:
- the exact unit boundaries for power-up, the supply dropout restart and the watchdog reset pulse;
- a lone rising kick edge, which must not service the watchdog;
- a period-select change part-way through a count;
- a half group of ticks, which must not advance any count.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WD_SEL_LONG  = 2'b00,
    WD_SEL_MID   = 2'b01,
    WD_SEL_SHORT = 2'b10,
    WD_SEL_OFF   = 2'b11
  } wd_sel_e;

  // Period in units for a select code; 0 means the watchdog is off.
  function automatic int unsigned wd_limit(input logic [1:0] sel,
                                           input int unsigned lng,
                                           input int unsigned mid,
                                           input int unsigned sht);
    case (wd_sel_e'(sel))
      WD_SEL_LONG:  return lng;
      WD_SEL_MID:   return mid;
      WD_SEL_SHORT: return sht;
      default:      return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_prescaler.sv
module sup_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  output logic unit
);
  generate
    if (DIV <= 1) begin : g_pass
      assign unit = tick;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] pcnt;
      assign unit = tick && (pcnt == PW'(DIV - 1));
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      pcnt <= '0;
        else if (unit)   pcnt <= '0;
        else if (tick)   pcnt <= pcnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sup_supply_qual.sv
module sup_supply_qual #(
  parameter int unsigned PUP_UNITS = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic unit,
  output logic hold
);
  localparam int unsigned QW = $clog2(PUP_UNITS + 1);
  logic [QW-1:0] qcnt;
  logic          q_done;

  assign q_done = hold && unit && (qcnt == QW'(PUP_UNITS - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold <= 1'b1;
      qcnt <= '0;
    end else if (!supply_ok) begin
      hold <= 1'b1;
      qcnt <= '0;
    end else if (q_done) begin
      hold <= 1'b0;
      qcnt <= '0;
    end else if (hold && unit) begin
      qcnt <= qcnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int unsigned WD_LONG_UNITS  = 9,
  parameter int unsigned WD_MID_UNITS   = 6,
  parameter int unsigned WD_SHORT_UNITS = 3,
  parameter int unsigned RST_UNITS      = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       unit,
  input  logic       kick_cs,
  input  logic [1:0] wd_sel,
  input  logic       sup_hold,
  output logic       wd_rst,
  output logic       wd_expire,
  output logic       kick_fall,
  output logic       wd_idle
);
  localparam int unsigned MAXL = max3(WD_LONG_UNITS, WD_MID_UNITS, WD_SHORT_UNITS);
  localparam int unsigned CW   = $clog2(MAXL + 1);
  localparam int unsigned RW   = $clog2(RST_UNITS + 1);

  logic [CW-1:0] wcnt;
  logic [RW-1:0] rcnt;
  logic          kick_q;
  logic [1:0]    sel_q;
  logic          sel_chg, restart, enabled, rst_active;
  int unsigned   lim;

  assign lim        = wd_limit(wd_sel, WD_LONG_UNITS, WD_MID_UNITS, WD_SHORT_UNITS);
  assign enabled    = (lim != 0);
  assign kick_fall  = kick_q && !kick_cs;
  assign sel_chg    = (sel_q != wd_sel);
  assign restart    = kick_fall || sel_chg;
  assign rst_active = sup_hold || wd_rst;
  assign wd_expire  = !rst_active && !restart && enabled && unit &&
                      (wcnt == CW'(lim - 1));
  assign wd_idle    = (wcnt == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      kick_q <= 1'b0;
      sel_q  <= 2'b00;
    end else begin
      kick_q <= kick_cs;
      sel_q  <= wd_sel;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                 wcnt <= '0;
    else if (rst_active || restart || !enabled) wcnt <= '0;
    else if (wd_expire)                         wcnt <= '0;
    else if (unit)                              wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_rst <= 1'b0;
      rcnt   <= '0;
    end else if (wd_expire) begin
      wd_rst <= 1'b1;
      rcnt   <= '0;
    end else if (wd_rst && unit) begin
      if (rcnt == RW'(RST_UNITS - 1)) begin
        wd_rst <= 1'b0;
        rcnt   <= '0;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned PRESC_DIV      = 2,
  parameter int unsigned PUP_UNITS      = 5,
  parameter int unsigned RST_UNITS      = 4,
  parameter int unsigned WD_LONG_UNITS  = 9,
  parameter int unsigned WD_MID_UNITS   = 6,
  parameter int unsigned WD_SHORT_UNITS = 3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       kick_cs,
  input  logic [1:0] wd_sel,
  output logic       rst_out,
  output logic       rst_out_n
);
  logic unit_w, sup_hold_w, wd_rst_w, wd_expire_w, kick_fall_w, wd_idle_w;

  sup_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .por_n(por_n), .tick(tick), .unit(unit_w)
  );

  sup_supply_qual #(.PUP_UNITS(PUP_UNITS)) u_qual (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .unit(unit_w),
    .hold(sup_hold_w)
  );

  sup_watchdog #(
    .WD_LONG_UNITS(WD_LONG_UNITS), .WD_MID_UNITS(WD_MID_UNITS),
    .WD_SHORT_UNITS(WD_SHORT_UNITS), .RST_UNITS(RST_UNITS)
  ) u_wd (
    .clk(clk), .por_n(por_n), .unit(unit_w), .kick_cs(kick_cs),
    .wd_sel(wd_sel), .sup_hold(sup_hold_w), .wd_rst(wd_rst_w),
    .wd_expire(wd_expire_w), .kick_fall(kick_fall_w), .wd_idle(wd_idle_w)
  );

  assign rst_out   = sup_hold_w || wd_rst_w;
  assign rst_out_n = !(sup_hold_w || wd_rst_w);
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk (
  input logic       clk,
  input logic       por_n,
  input logic       tick,
  input logic       supply_ok,
  input logic [1:0] wd_sel,
  input logic       rst_out,
  input logic       rst_out_n,
  input logic       unit,
  input logic       wd_expire,
  input logic       kick_fall,
  input logic       wd_idle
);
  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (!por_n)
    rst_out != rst_out_n); // R10

  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> rst_out); // R2

  AST_EXPIRE_RESET: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> rst_out); // R4

  AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!por_n)
    (wd_sel == 2'b11) |-> !wd_expire); // R5

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    kick_fall |=> wd_idle); // R6

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    rst_out |=> wd_idle); // R8

  AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (wd_sel != $past(wd_sel)) |=> wd_idle); // R9

  AST_UNIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n)
    unit |-> tick); // R11
endmodule

bind sup_reset_gen sup_reset_chk chk_i (
  .clk(clk), .por_n(por_n), .tick(tick), .supply_ok(supply_ok),
  .wd_sel(wd_sel), .rst_out(rst_out), .rst_out_n(rst_out_n),
  .unit(unit_w), .wd_expire(wd_expire_w), .kick_fall(kick_fall_w),
  .wd_idle(wd_idle_w)
);

// File: tb/sup_reset_gen_tb_top.sv
module sup_reset_gen_tb_top;
  localparam int DIV = 2, PUP = 5, RSTU = 4;
  localparam int LNG = 9, MID = 6, SHT = 3;

  logic clk = 1'b0, por_n = 1'b0, tick = 1'b0, supply_ok = 1'b1, kick_cs = 1'b0;
  logic [1:0] wd_sel = 2'b00;
  logic rst_out, rst_out_n;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sup_reset_gen #(
    .PRESC_DIV(DIV), .PUP_UNITS(PUP), .RST_UNITS(RSTU),
    .WD_LONG_UNITS(LNG), .WD_MID_UNITS(MID), .WD_SHORT_UNITS(SHT)
  ) dut_i (
    .clk(clk), .por_n(por_n), .tick(tick), .supply_ok(supply_ok),
    .kick_cs(kick_cs), .wd_sel(wd_sel), .rst_out(rst_out), .rst_out_n(rst_out_n)
  );

  // sel[15:14], units before a falling kick [13:8] (0 = none),
  // units from restart to expiry [7:0] (0 = never within 12 units)
  localparam logic [15:0] VEC [8] = '{
    {2'b00, 6'd0, 8'd9}, {2'b01, 6'd0, 8'd6}, {2'b10, 6'd0, 8'd3},
    {2'b11, 6'd0, 8'd0}, {2'b01, 6'd4, 8'd6}, {2'b10, 6'd2, 8'd3},
    {2'b00, 6'd7, 8'd9}, {2'b11, 6'd5, 8'd0}
  };

  task automatic check(input logic exp, input string tag);
    n_run++;
    if (rst_out !== exp || rst_out_n !== ~exp) begin
      n_fail++;
      $display("FAIL %s: rst_out=%b rst_out_n=%b expected %b/%b",
               tag, rst_out, rst_out_n, exp, ~exp);
    end
  endtask

  task automatic half_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic units(input int n);
    for (int i = 0; i < n * DIV; i++) half_tick();
  endtask

  task automatic kick();
    @(negedge clk) kick_cs = 1'b1;
    @(negedge clk) kick_cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic power_up(input logic [1:0] sel);
    @(negedge clk) por_n = 1'b0;
    wd_sel = sel; kick_cs = 1'b0; supply_ok = 1'b1; tick = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    units(PUP);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state and power-up boundary, R11 partial tick group
    repeat (3) @(negedge clk);
    check(1'b1, "R1 held while por_n low");
    por_n = 1'b1;
    units(PUP - 1);
    check(1'b1, "R1 before qualification ends");
    half_tick();
    check(1'b1, "R11 half group of ticks gives no unit");
    half_tick();
    check(1'b0, "R1 released after PUP units");

    // Table: R4 period per code, R5 off code, R6 falling kick restarts
    for (int i = 0; i < 8; i++) begin
      power_up(VEC[i][15:14]);
      check(1'b0, "R8 released before watchdog run");
      if (VEC[i][13:8] != 0) begin
        units(int'(VEC[i][13:8]));
        check(1'b0, "R6 no expiry before kick");
        kick();
      end
      if (VEC[i][7:0] == 0) begin
        units(12);
        check(1'b0, "R5 disabled code never expires");
      end else begin
        units(int'(VEC[i][7:0]) - 1);
        check(1'b0, "R4 one unit before period end");
        units(1);
        check(1'b1, "R4 expiry asserts reset");
      end
    end

    // R7 watchdog reset length, R8 restart from zero afterwards
    power_up(2'b10);
    units(SHT);
    check(1'b1, "R7 expiry");
    units(RSTU - 1);
    check(1'b1, "R7 still held one unit before end");
    units(1);
    check(1'b0, "R7 released after RST units");
    units(SHT - 1);
    check(1'b0, "R8 count restarted at release");
    units(1);
    check(1'b1, "R8 second expiry at full period");

    // R6 rising edge and high level do not service
    power_up(2'b10);
    units(SHT - 1);
    @(negedge clk) kick_cs = 1'b1;
    @(negedge clk);
    units(1);
    check(1'b1, "R6 rising kick does not restart");

    // R9 select change restarts count
    power_up(2'b10);
    units(SHT - 1);
    @(negedge clk) wd_sel = 2'b01;
    @(negedge clk);
    units(MID - 1);
    check(1'b0, "R9 no expiry after select change");
    units(1);
    check(1'b1, "R9 expiry at new period");

    // R3 dropout inside qualification restarts the window
    @(negedge clk) por_n = 1'b0;
    wd_sel = 2'b11; kick_cs = 1'b0;
    @(negedge clk) por_n = 1'b1;
    units(PUP - 2);
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk) supply_ok = 1'b1;
    units(PUP - 1);
    check(1'b1, "R3 window restarted after dropout");
    units(1);
    check(1'b0, "R3 released after full window");

    // R2 supply low while running
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk);
    check(1'b1, "R2 low supply asserts next edge");
    supply_ok = 1'b1;
    units(PUP - 1);
    check(1'b1, "R2 held until requalified");
    units(1);
    check(1'b0, "R2 released after requalification");

    finish_run();
  end
endmodule